// File: doc/BRIEF.md
# GPIO Port Register Block

This block is one general-purpose I/O port of up to 32 pins, controlled through a simple register bus. Each pin has a direction bit and an output latch. The pad value arriving at each pin is resynchronized to the block clock before software can see it.

Software has several ways to change the same output latch:

- a word per pin;
- write-one registers that set, clear or invert chosen pins;
- a masked-port register that touches only the pins enabled by a mask register.

For the mask register, a 0 bit enables a pin and a 1 bit excludes it. Reads come back one cycle after the address is presented. The output latch goes straight to the pads, and the direction bits drive the pad output enables.

The bus carries a word address, a write strobe, write data and registered read data. Word addresses 0x00 to 0x1F are the per-pin words. The remaining registers are:

| Word address | Register |
|---|---|
| 0x20 | direction |
| 0x21 | pin levels |
| 0x22 | mask |
| 0x23 | masked port |
| 0x24 | set |
| 0x25 | clear |
| 0x26 | invert |

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every direction bit is 0, every output latch is 0 and the mask register is 0, so pad_out and pad_oe are all zeros. Reading the direction register (0x20) or the mask register (0x22) returns 0.
- R2: A write to 0x20 loads the direction bits, where 1 means output and 0 means input. pad_oe follows the direction bits from the cycle after the write, and a read of 0x20 returns them.
- R3: A write to per-pin word N (address N, 0 to 31) loads bit 0 of the write data into the output latch of pin N. Upper data bits and all other pins are unaffected.
- R4: A read of per-pin word N returns the synchronized level of pin N in bit 0, with bits 31:1 zero.
- R5: A write to 0x24 sets to 1 the output latch of every pin whose data bit is 1. All other pins keep their value.
- R6: A write to 0x25 clears to 0 the output latch of every pin whose data bit is 1. All other pins keep their value.
- R7: A write to 0x26 inverts the output latch of every pin whose data bit is 1. All other pins keep their value.
- R8: A read of 0x21 returns the synchronized level of all pins. A pad change first appears in read data three clock edges after it is applied: two synchronizer stages plus the read register.
- R9: The mask register (0x22) reads back as written. A write to 0x23 updates only the output latches of pins whose mask bit is 0.
- R10: A read of 0x23 returns the synchronized pin levels of pins whose mask bit is 0. Pins whose mask bit is 1 read as 0.
- R11: Reads of 0x24, 0x25 and 0x26 return 0. Writes to 0x21 change no output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Word address of the access |
| bus_we | input | 1 | Write strobe for bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address of the previous cycle |
| pad_in | input | PINS | Raw pad levels, asynchronous |
| pad_out | output | PINS | Output latch driven to the pads |
| pad_oe | output | PINS | Pad output enable, equal to the direction bits |

## Verification
A write takes effect at the clock edge that samples it, so pad_out, pad_oe and later reads reflect it from the next cycle on. Read data is due exactly one edge after the address is driven. A pad change reaches read data only on the third edge. The bench therefore stamps each expected item with the cycle in which it is due, and the monitor compares only in that cycle. The pin-level latency check holds the address steady and expects the old value twice and the new value on the third edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned MAX_PINS = 32;
    localparam int unsigned PIN_IDX_W = $clog2(MAX_PINS);

    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h21;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h22;
    localparam logic [ADDR_W-1:0] OFS_MPORT = 8'h23;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h25;
    localparam logic [ADDR_W-1:0] OFS_INV   = 8'h26;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PIN,
        SEL_DIR,
        SEL_LEVEL,
        SEL_MASK,
        SEL_MPORT,
        SEL_SET,
        SEL_CLR,
        SEL_INV
    } reg_sel_e;

    typedef struct packed {
        logic                 we;
        reg_sel_e             sel;
        logic [PIN_IDX_W-1:0] pin;
        logic [DATA_W-1:0]    wdata;
    } bus_op_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned npins);
        reg_sel_e s;
        s = SEL_NONE;
        if (a < ADDR_W'(MAX_PINS)) begin
            if ({{(32-ADDR_W){1'b0}}, a} < npins) s = SEL_PIN;
        end else begin
            case (a)
                OFS_DIR:   s = SEL_DIR;
                OFS_LEVEL: s = SEL_LEVEL;
                OFS_MASK:  s = SEL_MASK;
                OFS_MPORT: s = SEL_MPORT;
                OFS_SET:   s = SEL_SET;
                OFS_CLR:   s = SEL_CLR;
                OFS_INV:   s = SEL_INV;
                default:   s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] level_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pad_i;
            stage2_q <= stage1_q;
        end
    end

    assign level_o = stage2_q;

    // Two edges out of reset, the level equals the pad value from two edges back.
    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (level_o == $past(pad_i, 2)));

endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_op_t      op_i,
    output logic [W-1:0] out_o,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] out_q, dir_q, mask_q;
    logic [W-1:0] wd;

    assign wd = op_i.wdata[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (op_i.we) begin
            case (op_i.sel)
                SEL_PIN: begin
                    for (int i = 0; i < int'(W); i++) begin
                        if (int'(op_i.pin) == i) out_q[i] <= op_i.wdata[0];
                    end
                end
                SEL_DIR:   dir_q  <= wd;
                SEL_MASK:  mask_q <= wd;
                SEL_MPORT: out_q  <= (out_q & mask_q) | (wd & ~mask_q);
                SEL_SET:   out_q  <= out_q | wd;
                SEL_CLR:   out_q  <= out_q & ~wd;
                SEL_INV:   out_q  <= out_q ^ wd;
                default:   ;
            endcase
        end
    end

    assign out_o  = out_q;
    assign dir_o  = dir_q;
    assign mask_o = mask_q;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_q == '0 && dir_q == '0 && mask_q == '0));

    assert_set_bits_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i.we && op_i.sel == SEL_SET) |=> (out_q == ($past(out_q) | $past(wd))));

    assert_clear_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i.we && op_i.sel == SEL_CLR) |=> ((out_q & $past(wd)) == '0));

    assert_invert_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i.we && op_i.sel == SEL_INV) |=> ((out_q ^ $past(out_q)) == $past(wd)));

    assert_masked_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i.we && op_i.sel == SEL_MPORT) |=> (((out_q ^ $past(out_q)) & $past(mask_q)) == '0));

    assert_level_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (op_i.we && op_i.sel == SEL_LEVEL) |=> $stable(out_q));

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  reg_sel_e             sel_i,
    input  logic [PIN_IDX_W-1:0] pin_i,
    input  logic [W-1:0]         level_i,
    input  logic [W-1:0]         dir_i,
    input  logic [W-1:0]         mask_i,
    output logic [DATA_W-1:0]    rdata_o
);
    logic [DATA_W-1:0] rd_d, rd_q;
    logic              pin_lvl;

    always_comb begin
        pin_lvl = 1'b0;
        for (int i = 0; i < int'(W); i++) begin
            if (int'(pin_i) == i) pin_lvl = level_i[i];
        end
    end

    always_comb begin
        rd_d = '0;
        case (sel_i)
            SEL_PIN:   rd_d[0]   = pin_lvl;
            SEL_DIR:   rd_d[W-1:0] = dir_i;
            SEL_LEVEL: rd_d[W-1:0] = level_i;
            SEL_MASK:  rd_d[W-1:0] = mask_i;
            SEL_MPORT: rd_d[W-1:0] = level_i & ~mask_i;
            default:   rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_d;
    end

    assign rdata_o = rd_q;

    assert_strobe_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SEL_SET || sel_i == SEL_CLR || sel_i == SEL_INV) |=> (rdata_o == '0));

    assert_masked_read_R10: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SEL_MPORT) |=> ((rdata_o[W-1:0] & $past(mask_i)) == '0));

    assert_pin_read_width_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_i == SEL_PIN) |=> (rdata_o[DATA_W-1:1] == '0));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe
);
    bus_op_t      op;
    logic [PINS-1:0] level, out_q, dir_q, mask_q;

    always_comb begin
        op.we    = bus_we;
        op.sel   = decode_addr(bus_addr, PINS);
        op.pin   = bus_addr[PIN_IDX_W-1:0];
        op.wdata = bus_wdata;
    end

    gpio_in_sync #(.W(PINS)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .pad_i   (pad_in),
        .level_o (level)
    );

    gpio_out_regs #(.W(PINS)) regs_i (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op),
        .out_o  (out_q),
        .dir_o  (dir_q),
        .mask_o (mask_q)
    );

    gpio_read_mux #(.W(PINS)) rmux_i (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (op.sel),
        .pin_i   (op.pin),
        .level_i (level),
        .dir_i   (dir_q),
        .mask_i  (mask_q),
        .rdata_o (bus_rdata)
    );

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    assert_oe_follows_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata[PINS-1:0])));

    assert_pin_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr < 8'(PINS)) |=>
        ((pad_out ^ $past(pad_out)) == (($past(pad_out) ^ {PINS{$past(bus_wdata[0])}})
                                        & (PINS'(1) << $past(bus_addr)))));

    if (PINS > 32 || PINS == 0) begin : g_bad_width
        initial $error("PINS must be 1..32");
    end

endmodule

// File: tb/gpio_port_regs_tb_top.sv
module gpio_port_regs_tb_top;

    localparam int unsigned N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pad_in, pad_out, pad_oe;
    logic [N-1:0] ext = '0;

    // Pad model: output pins loop back, input pins take the external level.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    always #4 clk = ~clk;

    gpio_port_regs #(.PINS(N)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct {
        int          due;
        int          kind;   // 0 read data, 1 pad_out, 2 pad_oe
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_out = '0, m_dir = '0, m_mask = '0;

    // Monitor: compares every item in the cycle it is due.
    always begin
        item_t it;
        logic [31:0] act;
        @(posedge clk);
        cyc++;
        #2;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? pad_out : pad_oe;
            checks++;
            if (it.due != cyc || act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h (kind %0d, cycle %0d)",
                         it.req, act, it.exp, it.kind, cyc);
            end
        end
    end

    function automatic logic [31:0] lvl();
        return (m_dir & m_out) | (~m_dir & ext);
    endfunction

    task automatic push(input int dly, input int kind, input logic [31:0] e, input string req);
        item_t it;
        it.due = cyc + dly; it.kind = kind; it.exp = e; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        case (a)
            8'h20: m_dir  = d;
            8'h22: m_mask = d;
            8'h23: m_out  = (m_out & m_mask) | (d & ~m_mask);
            8'h24: m_out  = m_out | d;
            8'h25: m_out  = m_out & ~d;
            8'h26: m_out  = m_out ^ d;
            default: if (a < 8'd32) m_out[a[4:0]] = d[0];
        endcase
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        bus_addr = a; bus_we = 1'b0;
        push(1, 0, e, req);
        @(negedge clk);
    endtask

    task automatic pads(input string req);
        push(1, 1, m_out, req);
        push(1, 2, m_dir, req);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h20, 32'h0, "R1");
        rd(8'h22, 32'h0, "R1");
        pads("R1");
        // R2 direction
        wr(8'h20, 32'h0000_FF0F);
        pads("R2");
        rd(8'h20, 32'h0000_FF0F, "R2");
        // R3 per-pin write
        wr(8'd3, 32'hFFFF_FFF1);
        pads("R3");
        wr(8'd3, 32'h0000_0002);
        pads("R3");
        wr(8'd9, 32'h1);
        pads("R3");
        // R4 per-pin read
        ext = 32'h0010_0000;
        settle();
        rd(8'd9, 32'h1, "R4");
        rd(8'd20, 32'h1, "R4");
        rd(8'd21, 32'h0, "R4");
        // R5 set
        wr(8'h24, 32'hF0F0_0001);
        pads("R5");
        // R6 clear
        wr(8'h25, 32'h3030_0201);
        pads("R6");
        // R7 invert
        wr(8'h26, 32'h0000_FFFF);
        pads("R7");
        // R8 pin levels and latency
        settle();
        rd(8'h21, lvl(), "R8");
        begin
            logic [31:0] old_v, new_v;
            old_v = lvl();
            ext = 32'h1234_0050;
            new_v = lvl();
            bus_addr = 8'h21;
            push(1, 0, old_v, "R8");
            push(2, 0, old_v, "R8");
            push(3, 0, new_v, "R8");
            repeat (3) @(negedge clk);
        end
        // R9 mask and masked write
        wr(8'h22, 32'hFFFF_0000);
        rd(8'h22, 32'hFFFF_0000, "R9");
        wr(8'h23, 32'hAAAA_AAAA);
        pads("R9");
        wr(8'h23, 32'h5555_5555);
        pads("R9");
        // R10 masked read
        settle();
        rd(8'h23, lvl() & ~m_mask, "R10");
        wr(8'h22, 32'h0F0F_0F0F);
        rd(8'h23, lvl() & ~m_mask, "R10");
        // R11 strobe registers read zero, level register write ignored
        rd(8'h24, 32'h0, "R11");
        rd(8'h25, 32'h0, "R11");
        rd(8'h26, 32'h0, "R11");
        bus_addr = 8'h21; bus_we = 1'b1; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_we = 1'b0;
        pads("R11");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: actual=%0d expected=0 items left", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule